// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial input into characters that software reads through a simple register port. Each frame is one low start bit, then 7 or 8 data bits least significant bit first, then an optional parity bit, then one high stop bit. Bits are sampled in the middle of a 16x oversampled bit period. The oversample tick comes from a fixed clock divider. Completed characters are stored in a single holding entry or, when the FIFO is enabled, in a small receive queue. The queue reports how many entries it holds.

The block keeps two sticky status flags. Overrun is set when a character completes and there is no room for it. Parity error is set when the received parity bit does not match the computed one. Pulsing the status read strobe clears both flags.

Where the received parity bit is reported depends on the frame length. In 7-bit frames it is placed in bit 7 of the data word. In 8-bit frames it is placed on a separate ninth-bit output.

Top module: `uart_rx_err`

## Requirements
- R1: Data bits are assembled least significant bit first. An 8-bit frame yields all eight bits on `rd_data`. A 7-bit frame without parity yields `rd_data[6:0]` with `rd_data[7]` = 0.
- R2: In a 7-bit frame with parity enabled, `rd_data[7]` holds the received parity bit, and `rd_bit9` is 0.
- R3: In an 8-bit frame with parity enabled, `rd_bit9` holds the received parity bit. Whenever parity is disabled, `rd_bit9` is 0.
- R4: With parity enabled, the expected parity bit is the XOR of the data bits. The expected bit is inverted when `cfg_par_odd` = 1. A stored character whose received bit differs from the expected bit sets `stat_parity_err`.
- R5: With the FIFO disabled, a character that completes while the holding entry is full sets `stat_overrun` and is discarded. The earlier character stays readable.
- R6: With the FIFO enabled, up to 4 characters are held and read back in arrival order, and no overrun occurs before then. A character arriving when all 4 entries are full sets `stat_overrun` and is discarded.
- R7: `fifo_count` equals the number of stored characters, and `data_valid` is 1 exactly when that number is nonzero. A pulse on `rd_data_en` removes the oldest character, and `rd_data`/`rd_bit9` read 0 while empty.
- R8: One cycle after a `rd_stat_en` pulse, both status flags read 0, unless a frame completed in that same cycle and raised a flag again.
- R9: A start bit that is no longer low at its mid-bit sample is rejected, and no character is produced.
- R10: After reset, `data_valid`, `fifo_count`, `stat_overrun` and `stat_parity_err` are all 0.
- R11: A character discarded for overrun does not affect `stat_parity_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial input, idles high |
| cfg_len8 | input | 1 | 1 = 8 data bits, 0 = 7 data bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_fifo_en | input | 1 | 1 = 4-entry queue, 0 = single holding entry |
| rd_data_en | input | 1 | Data read strobe; removes the oldest character |
| rd_stat_en | input | 1 | Status read strobe; clears both flags |
| rd_data | output | 8 | Oldest stored character (0 when empty) |
| rd_bit9 | output | 1 | Ninth-bit field of the oldest character |
| data_valid | output | 1 | At least one character is stored |
| fifo_count | output | 3 | Number of stored characters |
| stat_overrun | output | 1 | Sticky overrun flag |
| stat_parity_err | output | 1 | Sticky parity error flag |

## Verification
The bench targets the following corner cases:
- A 7-bit frame with parity. A design that routes the parity bit to the wrong place would show it on `rd_bit9` instead of data bit 7.
- A fifth character arriving at a full queue. A design with an off-by-one capacity check would accept it, or would raise overrun one character early.
- A bad-parity character that is also an overrun victim. A design that checks parity before deciding to store the character would set the parity flag for a character it then discards.
- Short low pulses on the line. A receiver without mid-bit confirmation would turn them into phantom characters.

Random frames mix lengths, parity modes and read patterns against a queue model kept in the bench.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [7:0] data;
        logic       bit9;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
    parameter int CLK_DIV = 27
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = (s_q.cnt == CW'(CLK_DIV - 1));
        if (tick) s_d.cnt = '0;
        else      s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     rxd,
    input  logic     cfg_len8,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    output logic     frm_done,
    output rx_char_t frm_char,
    output logic     frm_perr
);
    localparam int CW  = $clog2(OVS);
    localparam int MID = OVS / 2 - 1;

    typedef struct packed {
        logic [1:0]    sync;
        rx_state_e     st;
        logic [CW-1:0] os;
        logic [2:0]    idx;
        logic [7:0]    shreg;
        logic          acc;
        logic          rpar;
        logic          done;
        rx_char_t      chr;
        logic          perr;
    } des_st_t;

    des_st_t s_d, s_q;
    logic    rx_s;
    logic    os_end;
    logic [2:0] last_idx;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.sync = {s_q.sync[0], rxd};
        rx_s     = s_q.sync[1];
        os_end   = (s_q.os == CW'(OVS - 1));
        last_idx = cfg_len8 ? 3'd7 : 3'd6;
        if (tick) begin
            case (s_q.st)
                RX_IDLE: begin
                    if (!rx_s) begin
                        s_d.st = RX_START;
                        s_d.os = '0;
                    end
                end
                RX_START: begin
                    if (s_q.os == CW'(MID)) begin
                        s_d.os = '0;
                        if (rx_s) begin
                            s_d.st = RX_IDLE;
                        end else begin
                            s_d.st    = RX_DATA;
                            s_d.idx   = '0;
                            s_d.shreg = '0;
                            s_d.acc   = 1'b0;
                            s_d.rpar  = 1'b0;
                        end
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_DATA: begin
                    if (os_end) begin
                        s_d.os               = '0;
                        s_d.shreg[s_q.idx]   = rx_s;
                        s_d.acc              = s_q.acc ^ rx_s;
                        if (s_q.idx == last_idx) begin
                            s_d.st = cfg_par_en ? RX_PAR : RX_STOP;
                        end else begin
                            s_d.idx = s_q.idx + 1'b1;
                        end
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_PAR: begin
                    if (os_end) begin
                        s_d.os   = '0;
                        s_d.rpar = rx_s;
                        s_d.st   = RX_STOP;
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                RX_STOP: begin
                    if (os_end) begin
                        s_d.os   = '0;
                        s_d.st   = RX_IDLE;
                        s_d.done = 1'b1;
                        if (cfg_len8) begin
                            s_d.chr.data = s_q.shreg;
                            s_d.chr.bit9 = cfg_par_en & s_q.rpar;
                        end else begin
                            s_d.chr.data = {cfg_par_en & s_q.rpar, s_q.shreg[6:0]};
                            s_d.chr.bit9 = 1'b0;
                        end
                        s_d.perr = cfg_par_en && (s_q.rpar != (s_q.acc ^ cfg_par_odd));
                    end else begin
                        s_d.os = s_q.os + 1'b1;
                    end
                end
                default: s_d.st = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.sync <= 2'b11;
            s_q.st   <= RX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign frm_done = s_q.done;
    assign frm_char = s_q.chr;
    assign frm_perr = s_q.perr;
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       fifo_en,
    input  logic                       push,
    input  rx_char_t                   push_chr,
    input  logic                       push_perr,
    input  logic                       pop_req,
    input  logic                       stat_clr,
    output rx_char_t                   head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       ovr_flag,
    output logic                       perr_flag
);
    localparam int CNTW = $clog2(DEPTH + 1);
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        rx_char_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [CNTW-1:0]      cnt;
        logic                 ovr;
        logic                 perr;
    } st_t;

    st_t s_d, s_q;
    logic            pop;
    logic            accept;
    logic [CNTW-1:0] occ;
    logic [CNTW-1:0] cap;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        s_d    = s_q;
        pop    = pop_req && (s_q.cnt != '0);
        occ    = s_q.cnt - CNTW'(pop);
        cap    = fifo_en ? CNTW'(DEPTH) : CNTW'(1);
        accept = push && (occ < cap);
        if (pop) s_d.rp = nxt(s_q.rp);
        if (accept) begin
            s_d.mem[s_q.wp] = push_chr;
            s_d.wp          = nxt(s_q.wp);
        end
        s_d.cnt = occ + CNTW'(accept);
        if (stat_clr) begin
            s_d.ovr  = 1'b0;
            s_d.perr = 1'b0;
        end
        if (push && !accept)     s_d.ovr  = 1'b1;
        if (accept && push_perr) s_d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head      = (s_q.cnt != '0) ? s_q.mem[s_q.rp] : '0;
    assign count     = s_q.cnt;
    assign ovr_flag  = s_q.ovr;
    assign perr_flag = s_q.perr;
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
    import uart_rx_pkg::*;
#(
    parameter int CLK_DIV    = 27,
    parameter int OVS        = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    input  logic       cfg_len8,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_fifo_en,
    input  logic       rd_data_en,
    input  logic       rd_stat_en,
    output logic [7:0] rd_data,
    output logic       rd_bit9,
    output logic       data_valid,
    output logic [2:0] fifo_count,
    output logic       stat_overrun,
    output logic       stat_parity_err
);
    localparam int CNTW = $clog2(FIFO_DEPTH + 1);

    logic            tick;
    logic            frm_done;
    rx_char_t        frm_char;
    logic            frm_perr;
    rx_char_t        head;
    logic [CNTW-1:0] cnt;

    uart_rx_tick #(.CLK_DIV(CLK_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    uart_rx_deser #(.OVS(OVS)) i_deser (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .rxd        (rxd),
        .cfg_len8   (cfg_len8),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .frm_done   (frm_done),
        .frm_char   (frm_char),
        .frm_perr   (frm_perr)
    );

    uart_rx_store #(.DEPTH(FIFO_DEPTH)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (cfg_fifo_en),
        .push     (frm_done),
        .push_chr (frm_char),
        .push_perr(frm_perr),
        .pop_req  (rd_data_en),
        .stat_clr (rd_stat_en),
        .head     (head),
        .count    (cnt),
        .ovr_flag (stat_overrun),
        .perr_flag(stat_parity_err)
    );

    assign rd_data    = head.data;
    assign rd_bit9    = head.bit9;
    assign data_valid = (cnt != '0);
    assign fifo_count = 3'(cnt);
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk #(
    parameter int DEPTH = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_fifo_en,
    input logic       rd_data_en,
    input logic       rd_stat_en,
    input logic       frm_done,
    input logic       data_valid,
    input logic [2:0] fifo_count,
    input logic       stat_overrun,
    input logic       stat_parity_err
);
    AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_en && !frm_done) |=> (!stat_overrun && !stat_parity_err)); // R8

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_overrun && !rd_stat_en) |=> stat_overrun); // R5

    AST_OVR_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_overrun) |-> (fifo_count == (cfg_fifo_en ? 3'(DEPTH) : 3'd1))); // R6

    AST_SINGLE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && $past(!cfg_fifo_en)) |-> (fifo_count <= 3'd1)); // R5

    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_data_en && data_valid) && !frm_done) |=> $stable(fifo_count)); // R7

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_en && data_valid && !frm_done) |=> (fifo_count == $past(fifo_count) - 3'd1)); // R7

    AST_PERR_FROM_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_parity_err) |-> $past(frm_done)); // R4
endmodule

bind uart_rx_err uart_rx_err_chk #(.DEPTH(FIFO_DEPTH)) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_fifo_en    (cfg_fifo_en),
    .rd_data_en     (rd_data_en),
    .rd_stat_en     (rd_stat_en),
    .frm_done       (frm_done),
    .data_valid     (data_valid),
    .fifo_count     (fifo_count),
    .stat_overrun   (stat_overrun),
    .stat_parity_err(stat_parity_err)
);

// File: tb/test_uart_rx_err.sv
module test_uart_rx_err;
    localparam int CLK_DIV = 4;
    localparam int BT      = 16 * CLK_DIV;
    localparam int DEPTH   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_fifo_en = 1'b0;
    logic       rd_data_en = 1'b0, rd_stat_en = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit9, data_valid, stat_overrun, stat_parity_err;
    logic [2:0] fifo_count;

    int  n_chk = 0, n_fail = 0;
    bit  finished = 0;
    logic [8:0] q[$];
    bit  m_ovr = 0, m_perr = 0;

    always #10 clk = ~clk;

    uart_rx_err #(.CLK_DIV(CLK_DIV), .OVS(16), .FIFO_DEPTH(DEPTH)) i_uart_rx_err (
        .clk(clk), .rst_n(rst_n), .rxd(rxd),
        .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_fifo_en(cfg_fifo_en), .rd_data_en(rd_data_en), .rd_stat_en(rd_stat_en),
        .rd_data(rd_data), .rd_bit9(rd_bit9), .data_valid(data_valid),
        .fifo_count(fifo_count), .stat_overrun(stat_overrun), .stat_parity_err(stat_parity_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic good_par(input logic [7:0] d, input logic l8, input logic odd);
        return (^(l8 ? d : {1'b0, d[6:0]})) ^ odd;
    endfunction

    function automatic logic [8:0] mk_entry(input logic [7:0] d, input logic l8,
                                            input logic pe, input logic pb);
        if (l8) return {pe & pb, d};
        return {1'b0, pe & pb, d[6:0]};
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic bad);
        logic pb;
        int   nb;
        pb = good_par(d, cfg_len8, cfg_par_odd) ^ bad;
        nb = cfg_len8 ? 8 : 7;
        @(negedge clk);
        rxd = 1'b0;
        repeat (BT) @(negedge clk);
        for (int i = 0; i < nb; i++) begin
            rxd = d[i];
            repeat (BT) @(negedge clk);
        end
        if (cfg_par_en) begin
            rxd = pb;
            repeat (BT) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (2 * BT) @(negedge clk);
        if (q.size() < (cfg_fifo_en ? DEPTH : 1)) begin
            q.push_back(mk_entry(d, cfg_len8, cfg_par_en, pb));
            if (cfg_par_en && bad) m_perr = 1;
        end else begin
            m_ovr = 1;
        end
    endtask

    task automatic check_state(input string req);
        @(negedge clk);
        chk({req, " count"}, fifo_count, q.size());
        chk({req, " valid"}, data_valid, q.size() != 0);
        chk({req, " overrun"}, stat_overrun, m_ovr);
        chk({req, " parity_err"}, stat_parity_err, m_perr);
    endtask

    task automatic read_data(input string req);
        logic [8:0] exp;
        @(negedge clk);
        exp = (q.size() != 0) ? q[0] : 9'd0;
        chk({req, " data"}, {rd_bit9, rd_data}, exp);
        rd_data_en = 1'b1;
        @(negedge clk);
        rd_data_en = 1'b0;
        if (q.size() != 0) void'(q.pop_front());
        chk({req, " count after read"}, fifo_count, q.size());
    endtask

    task automatic read_stat(input string req);
        @(negedge clk);
        chk({req, " overrun"}, stat_overrun, m_ovr);
        chk({req, " parity_err"}, stat_parity_err, m_perr);
        rd_stat_en = 1'b1;
        @(negedge clk);
        rd_stat_en = 1'b0;
        m_ovr = 0;
        m_perr = 0;
        chk("R8 overrun cleared", stat_overrun, 0);
        chk("R8 parity_err cleared", stat_parity_err, 0);
    endtask

    task automatic drain();
        while (q.size() != 0) read_data("R7 drain");
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 valid", data_valid, 0);
        chk("R10 count", fifo_count, 0);
        chk("R10 overrun", stat_overrun, 0);
        chk("R10 parity_err", stat_parity_err, 0);
        repeat (BT) @(negedge clk);

        // R1 8-bit and 7-bit, no parity
        cfg_len8 = 1; cfg_par_en = 0;
        send_frame(8'hA5, 0); check_state("R1 8b");
        read_data("R1 8b");
        chk("R3 no-parity bit9", rd_bit9, 0);
        cfg_len8 = 0;
        send_frame(8'hFF, 0); check_state("R1 7b");
        read_data("R1 7b top bit zero");

        // R2 7-bit with parity, even and odd
        cfg_par_en = 1; cfg_par_odd = 0;
        send_frame(8'h13, 0); check_state("R2 even");
        read_data("R2 even parity in bit7");
        cfg_par_odd = 1;
        send_frame(8'h13, 0); check_state("R2 odd");
        read_data("R2 odd parity in bit7");

        // R4 bad parity, then R8 clear
        send_frame(8'h5A, 1); check_state("R4 bad parity 7b");
        read_data("R4 data kept");
        read_stat("R4");

        // R3 8-bit with parity
        cfg_len8 = 1; cfg_par_odd = 0;
        send_frame(8'h81, 0); check_state("R3 8b even");
        read_data("R3 bit9");
        cfg_par_odd = 1;
        send_frame(8'h7E, 1); check_state("R4 bad parity 8b");
        read_data("R3 bit9 odd");
        read_stat("R4 8b");

        // R5 overrun, holding entry only
        cfg_fifo_en = 0; cfg_par_en = 0;
        send_frame(8'h11, 0);
        send_frame(8'h22, 0); check_state("R5 overrun");
        read_data("R5 first kept");
        read_data("R7 empty reads zero");
        read_stat("R5");

        // R6 + R11: fill queue, fifth is bad-parity and discarded
        cfg_fifo_en = 1; cfg_par_en = 1; cfg_par_odd = 0;
        for (int i = 0; i < DEPTH; i++) begin
            send_frame(8'(8'h30 + i), 0);
            check_state("R6 filling");
        end
        send_frame(8'h99, 1); check_state("R11 discarded bad parity");
        chk("R6 full count", fifo_count, DEPTH);
        drain();
        read_stat("R6");

        // R9 glitch rejection
        @(negedge clk); rxd = 1'b0;
        repeat (3 * CLK_DIV) @(negedge clk);
        rxd = 1'b1;
        repeat (2 * BT) @(negedge clk);
        check_state("R9 glitch");

        // random frames
        for (int n = 0; n < 50; n++) begin
            if (q.size() == 0 && ($urandom % 4 == 0)) cfg_fifo_en = ~cfg_fifo_en;
            cfg_len8    = $urandom % 2;
            cfg_par_en  = $urandom % 2;
            cfg_par_odd = $urandom % 2;
            send_frame(8'($urandom), ($urandom % 5) == 0);
            check_state("R7 random");
            if ($urandom % 2 == 0) read_data("R1 random read");
            if ($urandom % 3 == 0) read_stat("R8 random");
        end
        drain();
        read_stat("R8 final");
        finish_run();
    end
endmodule